// File: doc/BRIEF.md
# Decode-Stage Interlock for a Multi-Latency In-Order Pipeline

This block sits beside the decode stage of an in-order five-stage pipeline whose execute stage fans out to units of very different depth: a single-cycle integer ALU, a load path, and floating-point add, multiply and divide pipes. Each cycle it looks at the decoded descriptor (unit class, destination, two optional sources, valid) and decides whether that instruction may leave decode. It holds the instruction when a source is still being produced by an older instruction, or when the cycle in which the instruction would use the single register-file write port is already claimed by an older instruction.

Every result still in flight has a per-register countdown of the cycles left before a consumer may issue. Future write-port cycles are kept in a shifting claim vector. A mode input picks forwarding timing (operands taken from the bypass network) or no-forwarding timing (operands read from the register file in the producer's write-back cycle). While decode is held, fetch and decode keep their contents and an empty slot goes into execute. In no-forwarding mode an issuing branch also squashes the fetched instruction.

Top module: `pipe_interlock`

## Requirements
- R1: After reset `ex_valid` is low, and a valid descriptor with no older producers in flight issues with `stall` low.
- R2: With `fwd_en` high, a consumer of register r is held for as many cycles as the producer's extra latency. Unit codes are 0 ALU, 1 load, 2 FP add, 3 FP multiply, 4 FP divide and 5 branch. The extra latencies are ALU 0, load 1, add 3, multiply 6 and divide 24.
- R3: With `fwd_en` low, a consumer leaves decode exactly in the producer's write-back cycle, which is a hold of (write-back offset - 1) cycles: 2 for ALU or load, 5 for add, 8 for multiply, 26 for divide.
- R4: An instruction that issues in cycle t with its destination write enabled claims write-back cycle t+3 for ALU, load and branch codes, and t+3+latency for FP codes. A younger instruction whose write-back cycle is already claimed is held until a free cycle comes up.
- R5: A source whose enable is low causes no hold. An instruction with its destination write disabled claims no write-back cycle and creates no dependence.
- R6: Instructions in different units overlap without a hold when they have no register dependence and do not need the same write-back cycle.
- R7: A cycle with `stall` high is followed by a cycle with `ex_valid` low (a bubble). A cycle in which a valid descriptor issues is followed by a cycle with `ex_valid` high.
- R8: `fetch_kill` is high exactly in the cycle a branch (code 5) leaves decode with `fwd_en` low. It is never high with `fwd_en` high.
- R9: `stall` is never high while `id_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 = forwarding timing, 0 = register-file timing |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_unit | input | 3 | Unit class code |
| id_dst | input | 5 | Destination register |
| id_dst_we | input | 1 | Instruction writes its destination |
| id_src1 | input | 5 | First source register |
| id_src1_en | input | 1 | First source is used |
| id_src2 | input | 5 | Second source register |
| id_src2_en | input | 1 | Second source is used |
| stall | output | 1 | Hold fetch and decode this cycle |
| ex_valid | output | 1 | Instruction now in execute is real (low = bubble) |
| fetch_kill | output | 1 | Squash the fetched instruction behind an issuing branch |

## Verification
The assertions check on every cycle that a hold only happens with an instruction present, that each hold puts a bubble into execute and each issue a valid slot, that the fetch squash only fires for a branch issuing in no-forwarding mode, and that no countdown goes past the deepest write-back offset. Only the bench's scenarios can show the exact number of hold cycles. These scenarios cover a load feeding a multiply feeding an add in both modes, write-port collisions between ALU results and long FP results, a divide colliding with a later multiply, and a consumer reading in the producer's write-back cycle.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int NREG      = 32,
  parameter int BASE_WB   = 3,
  parameter int LAT_LD    = 1,
  parameter int LAT_FADD  = 3,
  parameter int LAT_FMUL  = 6,
  parameter int LAT_FDIV  = 24,
  localparam int RW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic          id_valid,
  input  logic [2:0]    id_unit,
  input  logic [RW-1:0] id_dst,
  input  logic          id_dst_we,
  input  logic [RW-1:0] id_src1,
  input  logic          id_src1_en,
  input  logic [RW-1:0] id_src2,
  input  logic          id_src2_en,
  output logic          stall,
  output logic          ex_valid,
  output logic          fetch_kill
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LAT_MAX = imax(imax(LAT_LD, LAT_FADD), imax(LAT_FMUL, LAT_FDIV));
  localparam int WB_MAX  = BASE_WB + LAT_MAX;
  localparam int SLOTS   = WB_MAX + 1;
  localparam int CW      = $clog2(WB_MAX + 1);

  localparam logic [2:0] U_LD = 3'd1, U_FADD = 3'd2, U_FMUL = 3'd3, U_FDIV = 3'd4, U_BR = 3'd5;

  logic [CW-1:0]    lat_x, wb_off, wait_val;
  logic [CW-1:0]    cnt [NREG];
  logic [SLOTS-1:0] resv;
  logic             busy1, busy2, slot_taken, issue, writes;

  always_comb begin
    case (id_unit)
      U_LD:    lat_x = CW'(LAT_LD);
      U_FADD:  lat_x = CW'(LAT_FADD);
      U_FMUL:  lat_x = CW'(LAT_FMUL);
      U_FDIV:  lat_x = CW'(LAT_FDIV);
      default: lat_x = '0;
    endcase
  end

  assign wb_off     = (id_unit == U_LD) ? CW'(BASE_WB) : CW'(BASE_WB) + lat_x;
  assign wait_val   = fwd_en ? lat_x : wb_off - CW'(1);
  assign busy1      = id_src1_en && (cnt[id_src1] != '0);
  assign busy2      = id_src2_en && (cnt[id_src2] != '0);
  assign slot_taken = id_dst_we && resv[wb_off];
  assign stall      = id_valid && (busy1 || busy2 || slot_taken);
  assign issue      = id_valid && !stall;
  assign writes     = issue && id_dst_we;
  assign fetch_kill = issue && (id_unit == U_BR) && !fwd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv     <= '0;
      ex_valid <= 1'b0;
    end else begin
      resv     <= {1'b0, resv[SLOTS-1:1]} | (writes ? (SLOTS'(1) << (wb_off - CW'(1))) : '0);
      ex_valid <= issue;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] dec;
    assign dec = (cnt[r] == '0) ? '0 : cnt[r] - CW'(1);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[r] <= '0;
      else if (writes && (id_dst == RW'(r)))
        cnt[r] <= (wait_val > dec) ? wait_val : dec;
      else
        cnt[r] <= dec;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[r] <= CW'(WB_MAX));
  end

  assert_stall_needs_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> id_valid);
  assert_bubble_after_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);
  assert_valid_after_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall) |=> ex_valid);
  assert_kill_nofwd_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kill |-> (!fwd_en && id_valid && !stall));
endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fwd_en = 1'b1, id_valid = 1'b0, id_dst_we = 1'b0, id_src1_en = 1'b0, id_src2_en = 1'b0;
  logic [2:0] id_unit = 3'd0;
  logic [4:0] id_dst = '0, id_src1 = '0, id_src2 = '0;
  logic stall, ex_valid, fetch_kill;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pipe_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid), .id_unit(id_unit),
    .id_dst(id_dst), .id_dst_we(id_dst_we), .id_src1(id_src1), .id_src1_en(id_src1_en),
    .id_src2(id_src2), .id_src2_en(id_src2_en), .stall(stall), .ex_valid(ex_valid),
    .fetch_kill(fetch_kill));

  typedef struct packed {
    logic       fwd;
    logic [2:0] unit;
    logic [4:0] dst;
    logic       we;
    logic [4:0] s1;
    logic       s1en;
    logic [4:0] s2;
    logic       s2en;
    logic [7:0] gap;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1,  5'd1, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd2}, // R2 load
    '{1'b1, 3'd3,  5'd2, 1'b1,  5'd1, 1'b1,  5'd0, 1'b0, 8'd0,  8'd1,  4'd2}, // R2 mul after load
    '{1'b1, 3'd2,  5'd3, 1'b1,  5'd2, 1'b1,  5'd4, 1'b1, 8'd0,  8'd6,  4'd2}, // R2 add after mul
    '{1'b0, 3'd1,  5'd1, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd3}, // R3 load
    '{1'b0, 3'd3,  5'd2, 1'b1,  5'd1, 1'b1,  5'd0, 1'b0, 8'd0,  8'd2,  4'd3}, // R3 mul after load
    '{1'b0, 3'd2,  5'd3, 1'b1,  5'd2, 1'b1,  5'd4, 1'b1, 8'd0,  8'd8,  4'd3}, // R3 add after mul
    '{1'b1, 3'd2,  5'd5, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd4}, // R4 add claims t+6
    '{1'b1, 3'd0,  5'd6, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd0,  8'd0,  4'd4}, // R4
    '{1'b1, 3'd0,  5'd7, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd0,  8'd0,  4'd4}, // R4
    '{1'b1, 3'd0,  5'd8, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd0,  8'd1,  4'd4}, // R4 collides
    '{1'b1, 3'd4,  5'd9, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd4}, // R4 div t+27
    '{1'b1, 3'd3, 5'd10, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd17, 8'd1,  4'd4}, // R4 mul at t+18
    '{1'b0, 3'd0, 5'd11, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd3}, // R3
    '{1'b0, 3'd0, 5'd12, 1'b1, 5'd11, 1'b1,  5'd0, 1'b0, 8'd1,  8'd1,  4'd3}, // R3 same-cycle read
    '{1'b1, 3'd0, 5'd13, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd2}, // R2
    '{1'b1, 3'd0, 5'd14, 1'b1, 5'd13, 1'b1,  5'd0, 1'b0, 8'd0,  8'd0,  4'd2}, // R2 ALU bypass
    '{1'b1, 3'd3, 5'd15, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd6}, // R6
    '{1'b1, 3'd0, 5'd16, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd0,  8'd0,  4'd6}, // R6 overlap
    '{1'b1, 3'd2, 5'd19, 1'b0,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd5}, // R5 no write
    '{1'b1, 3'd0, 5'd20, 1'b1, 5'd19, 1'b1,  5'd0, 1'b0, 8'd2,  8'd0,  4'd5}, // R5 no claim, no dep
    '{1'b1, 3'd4, 5'd21, 1'b1,  5'd0, 1'b0,  5'd0, 1'b0, 8'd30, 8'd0,  4'd2}  // R2 divide
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [2:0] u, input logic [4:0] d, input logic w,
                       input logic [4:0] a, input logic ae, input logic [4:0] b, input logic be);
    fwd_en = f; id_unit = u; id_dst = d; id_dst_we = w;
    id_src1 = a; id_src1_en = ae; id_src2 = b; id_src2_en = be; id_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic issue_count(output int n);
    n = 0;
    #1;
    while (stall && n < 200) begin
      n++;
      @(posedge clk); @(negedge clk); #1;
    end
    @(posedge clk); @(negedge clk);
    id_valid = 1'b0;
  endtask

  initial begin : main
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 ex_valid after reset", ex_valid, 0);
    drive(1'b1, 3'd0, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1);
    #1 check("R1 stall with nothing in flight", stall, 0);
    @(posedge clk); @(negedge clk); id_valid = 1'b0;

    for (int k = 0; k < NV; k++) begin
      idle(int'(TBL[k].gap));
      drive(TBL[k].fwd, TBL[k].unit, TBL[k].dst, TBL[k].we,
            TBL[k].s1, TBL[k].s1en, TBL[k].s2, TBL[k].s2en);
      issue_count(n);
      check($sformatf("R%0d hold cycles, row %0d", TBL[k].req, k), n, int'(TBL[k].exp));
    end
    // divide consumer: R2 hold of 24
    drive(1'b1, 3'd0, 5'd22, 1'b1, 5'd21, 1'b1, 5'd0, 1'b0);
    issue_count(n);
    check("R2 divide consumer hold", n, 24);
    // second source path, no forwarding: R3 hold of 5
    idle(30);
    drive(1'b0, 3'd2, 5'd23, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    issue_count(n);
    drive(1'b0, 3'd0, 5'd24, 1'b1, 5'd0, 1'b0, 5'd23, 1'b1);
    issue_count(n);
    check("R3 add to second source hold", n, 5);
    // disabled source after a load: R5
    idle(30);
    drive(1'b1, 3'd1, 5'd17, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    issue_count(n);
    drive(1'b1, 3'd0, 5'd18, 1'b1, 5'd17, 1'b0, 5'd17, 1'b0);
    issue_count(n);
    check("R5 disabled sources", n, 0);

    // bubble sequence: R7, and stall gated by valid: R9
    idle(30);
    drive(1'b1, 3'd1, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    id_valid = 1'b0; id_unit = 3'd0; id_src1 = 5'd1; id_src1_en = 1'b1;
    #1 check("R9 no stall without valid", stall, 0);
    check("R7 load in execute", ex_valid, 1);
    idle(30);
    drive(1'b1, 3'd1, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(1'b1, 3'd0, 5'd2, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0);
    #1 check("R7 consumer held", stall, 1);
    @(posedge clk); @(negedge clk); #1;
    check("R7 bubble in execute", ex_valid, 0);
    check("R7 consumer released", stall, 0);
    @(posedge clk); @(negedge clk); id_valid = 1'b0; #1;
    check("R7 consumer in execute", ex_valid, 1);

    // branch squash: R8
    idle(30);
    drive(1'b0, 3'd5, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    #1 check("R8 squash without forwarding", fetch_kill, 1);
    @(posedge clk); @(negedge clk);
    drive(1'b1, 3'd5, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    #1 check("R8 no squash with forwarding", fetch_kill, 0);
    @(posedge clk); @(negedge clk); id_valid = 1'b0;
    #1 check("R8 no squash when idle", fetch_kill, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule